// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences one successive-approximation conversion at a time for an analog converter that sits outside it. Software writes an 8-bit control word over a simple register bus. The word picks four things: how the master clock is divided into the converter clock, how many converter clocks the track-and-hold gets to acquire, which start sources are live, and how the converter is powered between conversions.

A conversion can start in three ways: a software pulse, every second overflow of a timer, or a falling edge on an asynchronous active-low start pin. Once a start is accepted, the block holds the track-and-hold in acquire for the chosen number of converter clocks. It then runs 17 conversion clocks and raises a one-cycle done strobe. A busy flag covers both phases. The power-down and standby outputs follow the mode field: they are lifted while a conversion is in progress and restored one converter clock after the done strobe.

Top module: `adc_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x20. `adc_busy`, `adc_track` and `adc_done` are 0, `adc_pwr_down` is 1 and `adc_standby` is 0.
- R2: The mode field is `cfg_rdata[7:6]`. In mode 00 `adc_pwr_down` is 1. In mode 01 both power outputs are 0. In mode 10 `adc_pwr_down` is 1 while idle. In mode 11 `adc_standby` is 1 while idle. The two power outputs are never high together.
- R3: Bits [5:4] select a divide ratio of 1, 2, 4 or 8 for codes 00, 01, 10 and 11. A register write restarts the divider phase. For a software start in the cycle after a write, `adc_busy` is high for k + (A+16)·D cycles, where D is the ratio, A is the acquisition count and k = max(D−1, 1).
- R4: Bits [3:2] select an acquisition of A = 1, 2, 4 or 8 converter clocks for codes 00, 01, 10 and 11. Each conversion begins with `adc_track` high for k + (A−1)·D cycles, and `adc_track` is only ever high while `adc_busy` is high.
- R5: A conversion lasts 17 converter clocks. `adc_done` is high for exactly one cycle, on the converter-clock tick that ends the 17th clock, and `adc_busy` is low in that same cycle.
- R6: `sw_start` starts a conversion only when the block is idle and the mode is not 00. Start requests during a conversion, or during the converter clock after it, are ignored.
- R7: When bit 1 is set, every second `tmr_ovf` pulse starts a conversion. When bit 1 is clear, overflows do nothing. Any register write resets the overflow parity, so two new overflows are needed after it.
- R8: When bit 0 is set, a falling edge of `ext_start_n` (after a two-flop synchronizer) starts a conversion, and busy rises three clock edges after the pin falls. Holding the pin low does not start a second conversion. When bit 0 is clear, the pin does nothing.
- R9: In modes 10 and 11, both power outputs are 0 from the accepted start until one converter clock after `adc_done`. They then return to their idle value.
- R10: Writing mode 00 during a conversion aborts it: `adc_busy` falls at the write and no `adc_done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| sw_start | input | 1 | Software start pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_start_n | input | 1 | Asynchronous active-low start pin |
| adc_clk_en | output | 1 | One-cycle converter clock tick |
| adc_busy | output | 1 | Acquisition or conversion in progress |
| adc_track | output | 1 | Track-and-hold in acquire |
| adc_done | output | 1 | One-cycle conversion-complete strobe |
| adc_pwr_down | output | 1 | Converter powered down |
| adc_standby | output | 1 | Converter in standby |

## Verification
The bench builds the block with its default parameters: 17 conversion clocks, 2-bit divider and acquisition selectors, and two synchronizer stages. With these values every divide ratio from 1 to 8 and every acquisition length from 1 to 8 can be reached, so the random runs cover busy windows from 18 to 199 cycles. They also cover the single-cycle tail when the divider ratio is 1. The synchronizer depth fixes a three-edge start latency on the external pin, which the bench checks to the exact cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_OFF      = 2'b00,
        PM_ON       = 2'b01,
        PM_AUTO_OFF = 2'b10,
        PM_AUTO_SBY = 2'b11
    } pwr_mode_e;

    // control word layout, MSB first
    typedef struct packed {
        pwr_mode_e  mode;
        logic [1:0] div_sel;
        logic [1:0] acq_sel;
        logic       tmr_en;
        logic       ext_en;
    } ctrl_t;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_regs_t;

    div_regs_t div_d, div_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    always_comb begin
        div_d = div_q;
        limit = CNT_W'((1 << sel) - 1);
        wrap  = (div_q.cnt == limit);
        if (clr) begin
            div_d.cnt = '0;
        end else if (wrap) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        tick = wrap && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic tmr_en,
    input  logic ext_en,
    input  logic sw_start,
    input  logic tmr_ovf,
    input  logic ext_start_n,
    output logic start_req
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   parity;
    } trig_regs_t;

    trig_regs_t trg_d, trg_q;
    logic pin_s;
    logic pin_fall;
    logic tmr_fire;

    always_comb begin
        trg_d      = trg_q;
        pin_s      = trg_q.sync[SYNC_STAGES-1];
        trg_d.sync = {trg_q.sync[SYNC_STAGES-2:0], ext_start_n};
        trg_d.prev = pin_s;
        pin_fall   = trg_q.prev && !pin_s;

        tmr_fire = tmr_en && tmr_ovf && trg_q.parity && !cfg_wr;
        if (cfg_wr) begin
            trg_d.parity = 1'b0;
        end else if (tmr_en && tmr_ovf) begin
            trg_d.parity = !trg_q.parity;
        end

        start_req = sw_start || tmr_fire || (ext_en && pin_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trg_q.sync   <= '1;
            trg_q.prev   <= 1'b1;
            trg_q.parity <= 1'b0;
        end else begin
            trg_q <= trg_d;
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_CLKS = 17,
    parameter int ACQ_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pwr_mode_e            mode,
    input  logic [ACQ_SEL_W-1:0] acq_sel,
    input  logic                 abort,
    input  logic                 tick,
    input  logic                 start_req,
    output logic                 busy,
    output logic                 track,
    output logic                 done,
    output logic                 pwr_down,
    output logic                 standby
);
    localparam int ACQ_MAX = 1 << ((1 << ACQ_SEL_W) - 1);
    localparam int CNT_MAX = (CONV_CLKS > ACQ_MAX) ? CONV_CLKS : ACQ_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CLKS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;
    logic [CNT_W-1:0] acq_last;
    logic             idle_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        acq_last   = CNT_W'((1 << acq_sel) - 1);

        unique case (fsm_q.st)
            ST_IDLE: begin
                if (start_req && (mode != PM_OFF)) begin
                    fsm_d.st  = ST_ACQ;
                    fsm_d.cnt = '0;
                end
            end
            ST_ACQ: begin
                if (tick) begin
                    if (fsm_q.cnt == acq_last) begin
                        fsm_d.st  = ST_CONV;
                        fsm_d.cnt = '0;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (fsm_q.cnt == CONV_LAST) begin
                        fsm_d.st   = ST_TAIL;
                        fsm_d.cnt  = '0;
                        fsm_d.done = 1'b1;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    fsm_d.st = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase

        if (abort) begin
            fsm_d.st   = ST_IDLE;
            fsm_d.cnt  = '0;
            fsm_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_IDLE;
            fsm_q.cnt  <= '0;
            fsm_q.done <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        idle_q   = (fsm_q.st == ST_IDLE);
        busy     = (fsm_q.st == ST_ACQ) || (fsm_q.st == ST_CONV);
        track    = (fsm_q.st == ST_ACQ);
        done     = fsm_q.done;
        pwr_down = (mode == PM_OFF) || ((mode == PM_AUTO_OFF) && idle_q);
        standby  = (mode == PM_AUTO_SBY) && idle_q;
    end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int          CONV_CLKS   = 17,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTRL_RESET  = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       sw_start,
    input  logic       tmr_ovf,
    input  logic       ext_start_n,
    output logic       adc_clk_en,
    output logic       adc_busy,
    output logic       adc_track,
    output logic       adc_done,
    output logic       adc_pwr_down,
    output logic       adc_standby
);
    localparam int SEL_W = $bits(ctrl_t) / 4;

    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr_word;
    logic  abort;
    logic  start_req;

    always_comb begin
        wr_word = ctrl_t'(cfg_wdata);
        ctrl_d  = cfg_wr ? wr_word : ctrl_q;
        abort   = cfg_wr && (wr_word.mode == PM_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cfg_rdata = ctrl_q;

    adc_seq_clkdiv #(
        .SEL_W (SEL_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_wr),
        .sel   (ctrl_q.div_sel),
        .tick  (adc_clk_en)
    );

    adc_seq_trig #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .tmr_en      (ctrl_q.tmr_en),
        .ext_en      (ctrl_q.ext_en),
        .sw_start    (sw_start),
        .tmr_ovf     (tmr_ovf),
        .ext_start_n (ext_start_n),
        .start_req   (start_req)
    );

    adc_seq_fsm #(
        .CONV_CLKS (CONV_CLKS),
        .ACQ_SEL_W (SEL_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ctrl_q.mode),
        .acq_sel   (ctrl_q.acq_sel),
        .abort     (abort),
        .tick      (adc_clk_en),
        .start_req (start_req),
        .busy      (adc_busy),
        .track     (adc_track),
        .done      (adc_done),
        .pwr_down  (adc_pwr_down),
        .standby   (adc_standby)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       adc_clk_en,
    input logic       adc_busy,
    input logic       adc_track,
    input logic       adc_done,
    input logic       adc_pwr_down,
    input logic       adc_standby
);
    p_pwr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_pwr_down && adc_standby));

    p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:6] == 2'b00) |-> (!adc_busy && adc_pwr_down));

    p_on_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:6] == 2'b01) |-> (!adc_pwr_down && !adc_standby));

    p_track_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_track |-> adc_busy);

    p_begin_acq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_busy) |-> adc_track);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> !adc_done);

    p_done_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_done) |-> $past(adc_clk_en));

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |-> (!adc_busy && $past(adc_busy)));

    p_awake_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_busy |-> (!adc_pwr_down && !adc_standby));

endmodule

bind adc_seq adc_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .adc_clk_en   (adc_clk_en),
    .adc_busy     (adc_busy),
    .adc_track    (adc_track),
    .adc_done     (adc_done),
    .adc_pwr_down (adc_pwr_down),
    .adc_standby  (adc_standby)
);

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       sw_start = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       ext_start_n = 1'b1;
    logic       adc_clk_en, adc_busy, adc_track, adc_done, adc_pwr_down, adc_standby;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .sw_start     (sw_start),
        .tmr_ovf      (tmr_ovf),
        .ext_start_n  (ext_start_n),
        .adc_clk_en   (adc_clk_en),
        .adc_busy     (adc_busy),
        .adc_track    (adc_track),
        .adc_done     (adc_done),
        .adc_pwr_down (adc_pwr_down),
        .adc_standby  (adc_standby)
    );

    task automatic chkv(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            report();
        end
    end

    function automatic int exp_busy(input logic [7:0] c);
        int r = 1 << c[5:4];
        int a = 1 << c[3:2];
        int k = (r == 1) ? 1 : r - 1;
        return k + (a + 16) * r;
    endfunction

    function automatic int exp_track(input logic [7:0] c);
        int r = 1 << c[5:4];
        int a = 1 << c[3:2];
        int k = (r == 1) ? 1 : r - 1;
        return k + (a - 1) * r;
    endfunction

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_ovf();
        tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    task automatic settle();
        int g = 0;
        while (adc_busy && g < 1000) begin
            @(negedge clk);
            g++;
        end
        repeat (20) @(negedge clk);
    endtask

    // software-started conversion right after a register write
    task automatic sw_conv(input logic [7:0] c, input bit poke);
        int r = 1 << c[5:4];
        int nb = 0, nt = 0, awake_bad = 0, g = 0;
        logic [1:0] md = c[7:6];
        wr_cfg(c);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        while (adc_busy && g < 1000) begin
            nb++;
            if (adc_track) nt++;
            if (adc_pwr_down || adc_standby) awake_bad++;
            sw_start = (poke && nb == 4);
            @(negedge clk);
            g++;
        end
        sw_start = 1'b0;
        chkv("R3 busy cycles", nb, exp_busy(c));
        chkv("R4 track cycles", nt, exp_track(c));
        chkv("R5 done at busy fall", int'(adc_done), 1);
        chkv("R9 awake during conversion", awake_bad, 0);
        if (md[1]) chkv("R9 still awake at done", int'(adc_pwr_down | adc_standby), 0);
        for (int j = 1; j <= r; j++) begin
            @(negedge clk);
            if (j == 1) chkv("R5 done one cycle", int'(adc_done), 0);
            if (md[1] && (j == r - 1 || j == r)) begin
                chkv("R9 sleep after one adc clock",
                     int'(md[0] ? adc_standby : adc_pwr_down), (j == r) ? 1 : 0);
            end
        end
        if (poke) begin
            repeat (4) @(negedge clk);
            chkv("R6 start during conversion ignored", int'(adc_busy), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chkv("R1 reset rdata", int'(cfg_rdata), 32'h20);
        chkv("R1 reset busy", int'(adc_busy), 0);
        chkv("R1 reset track", int'(adc_track), 0);
        chkv("R1 reset done", int'(adc_done), 0);
        chkv("R1 reset pwr_down", int'(adc_pwr_down), 1);
        chkv("R1 reset standby", int'(adc_standby), 0);

        // R6 start in mode 00 ignored
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (3) @(negedge clk);
        chkv("R6 start in mode 00 ignored", int'(adc_busy), 0);

        // R2 idle power outputs per mode
        wr_cfg(8'h40); @(negedge clk);
        chkv("R2 mode 01 pwr", int'({adc_pwr_down, adc_standby}), 0);
        wr_cfg(8'h80); @(negedge clk);
        chkv("R2 mode 10 pwr", int'({adc_pwr_down, adc_standby}), 2);
        wr_cfg(8'hC0); @(negedge clk);
        chkv("R2 mode 11 pwr", int'({adc_pwr_down, adc_standby}), 1);
        wr_cfg(8'h00); @(negedge clk);
        chkv("R2 mode 00 pwr", int'({adc_pwr_down, adc_standby}), 2);

        // directed corners: R3 divider extremes, R4 acquisition extremes
        sw_conv(8'h40, 1'b0);
        sw_conv(8'h7C, 1'b1);
        sw_conv(8'hB0, 1'b1);
        sw_conv(8'hCC, 1'b0);

        // R7 timer overflow start
        wr_cfg(8'h42);
        pulse_ovf();
        repeat (3) @(negedge clk);
        chkv("R7 first overflow no start", int'(adc_busy), 0);
        pulse_ovf();
        chkv("R7 second overflow starts", int'(adc_busy), 1);
        settle();
        pulse_ovf();
        wr_cfg(8'h42);
        pulse_ovf();
        repeat (3) @(negedge clk);
        chkv("R7 write clears parity", int'(adc_busy), 0);
        pulse_ovf();
        chkv("R7 two fresh overflows start", int'(adc_busy), 1);
        settle();
        wr_cfg(8'h40);
        pulse_ovf();
        pulse_ovf();
        repeat (3) @(negedge clk);
        chkv("R7 overflow disabled ignored", int'(adc_busy), 0);

        // R8 external pin start
        wr_cfg(8'h41);
        ext_start_n = 1'b0;
        repeat (2) @(negedge clk);
        chkv("R8 no start before sync", int'(adc_busy), 0);
        @(negedge clk);
        chkv("R8 start third edge", int'(adc_busy), 1);
        begin
            int nd = 0;
            for (int i = 0; i < 60; i++) begin
                if (adc_done) nd++;
                @(negedge clk);
            end
            chkv("R8 held low one conversion", nd, 1);
            chkv("R8 held low stays idle", int'(adc_busy), 0);
        end
        ext_start_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_cfg(8'h40);
        ext_start_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_start_n = 1'b1;
        repeat (4) @(negedge clk);
        chkv("R8 pin disabled ignored", int'(adc_busy), 0);

        // R10 abort by writing mode 00
        wr_cfg(8'h50);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (10) @(negedge clk);
        wr_cfg(8'h10);
        chkv("R10 abort busy low", int'(adc_busy), 0);
        begin
            int nd = 0;
            for (int i = 0; i < 80; i++) begin
                if (adc_done) nd++;
                @(negedge clk);
            end
            chkv("R10 no done after abort", nd, 0);
            chkv("R10 powered down", int'(adc_pwr_down), 1);
        end

        // random configurations, R3 R4 R5 R6 R9
        for (int it = 0; it < 30; it++) begin
            logic [7:0] c;
            logic [1:0] md;
            md = 2'($urandom_range(3, 1));
            c = {md, 2'($urandom), 2'($urandom), 2'b00};
            sw_conv(c, 1'($urandom));
        end

        report();
    end

endmodule